// File: doc/BRIEF.md
# Offset QPSK Pulse Phase Mapper

This block sits in a pulse-based radio transmitter between the baseband data source and an analog multiplexer that picks one of four quadrature carrier phases for each pulse. Each clock cycle is one pulse slot. For every slot, the block drives a one-hot phase select and its bitwise complement. It also drives an envelope gate that tells the pulse generator whether to fire in that slot.

Data arrives one bit at a time over a valid/ready handshake. Two mapping modes are available.
- In BPSK mode, a bit chooses between 0° and 180°.
- In offset-QPSK mode, accepted bits alternate between the in-phase and quadrature halves of a Gray-coded pair. Only one half changes per accepted bit, so consecutive pulses step by 0° or ±90° and never by 180°.

A spreading setting repeats each accepted bit over 1, 2 or 4 pulse slots, which lowers the data rate in exchange for processing gain. When no bit is offered at a symbol boundary, the envelope gate drops and the last phase is held.

Top module: `pulse_phase_mapper`

## Requirements
- R1: `phaseSel` is one-hot at all times. Bit k selects the carrier phase k×90° (bit0 = 0°, bit1 = 90°, bit2 = 180°, bit3 = 270°).
- R2: `phaseSelN` is the bitwise inverse of `phaseSel` in every cycle. Both are registered on the same clock edge.
- R3: The held pair {I,Q} maps to the select as follows: 00 → 0° (bit0), 01 → 90° (bit1), 11 → 180° (bit2), 10 → 270° (bit3).
- R4: In offset-QPSK mode (`qpskMode`=1), accepted bits alternate between lanes. The first bit after reset, or after any BPSK bit, replaces I; the next replaces Q; and so on. The other bit holds, so the select never moves by 180° on an offset-QPSK bit.
- R5: In BPSK mode (`qpskMode`=0), an accepted bit b sets I=Q=b, so 0 gives 0° and 1 gives 180°. The next offset-QPSK bit then goes to the I lane.
- R6: `bitReady` is high exactly when the block is at a symbol boundary. A bit is taken when `bitValid` and `bitReady` are both high. Its phase and the envelope appear at the outputs in the cycle after the accepting edge.
- R7: `spreadSel` sets the number of pulse slots per bit: 00 → 1, 01 → 2, 10 or 11 → 4. Mode and spread are sampled when the bit is accepted. `envGate` stays high for exactly that many slots, and `bitReady` stays low between them.
- R8: At a symbol boundary with no valid bit, the next cycle has `envGate` low and an unchanged `phaseSel`.
- R9: A synchronous reset (`rst` high at a clock edge) sets the select to 0°, turns `envGate` off, clears I and Q, points the lane at I and raises `bitReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pulse-slot clock |
| rst | input | 1 | Synchronous active-high reset |
| qpskMode | input | 1 | 1 = offset-QPSK mapping, 0 = BPSK mapping |
| spreadSel | input | 2 | Pulses per bit: 00 = 1, 01 = 2, 1x = 4 |
| bitValid | input | 1 | Data bit offered |
| bitData | input | 1 | Data bit value |
| bitReady | output | 1 | Block can take a bit this cycle |
| phaseSel | output | 4 | One-hot carrier phase select |
| phaseSelN | output | 4 | Complement of phaseSel |
| envGate | output | 1 | Fire a pulse in this slot |

## Verification
The properties assume the following about the inputs:
- `rst` is held across at least one clock edge before checking starts.
- The inputs never carry unknown values.
- Inputs change only away from the rising edge.

The no-half-turn property assumes nothing about mode switching. It checks only edges that load an offset-QPSK bit, so a BPSK-to-offset switch is allowed. The stimulus drives every input on the falling edge from a seeded generator. Offer density, mode and spread are changed mid-stream, including inside a spread burst, to confirm that the values sampled at acceptance govern the burst.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  localparam int PHASE_CNT = 4;
  localparam int SPREAD_MAX = 4;
  localparam int CNT_W = $clog2(SPREAD_MAX);

  typedef struct packed {
    logic load;
    logic oqpsk;
  } ppm_strobe_t;

  function automatic logic [1:0] grayIndex(input logic iBit, input logic qBit);
    return {iBit, iBit ^ qBit};
  endfunction
endpackage

// File: rtl/ppm_ctrl.sv
module ppm_ctrl
  import ppm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        qpskMode,
  input  logic [1:0]  spreadSel,
  input  logic        bitValid,
  output logic        bitReady,
  output logic        envGate,
  output ppm_strobe_t stb
);
  logic [CNT_W-1:0] chipCnt;
  logic [CNT_W-1:0] spanM1;
  logic [CNT_W-1:0] newSpanM1;
  logic             accept;

  always_comb begin
    case (spreadSel)
      2'b00:   newSpanM1 = CNT_W'(0);
      2'b01:   newSpanM1 = CNT_W'(1);
      default: newSpanM1 = CNT_W'(SPREAD_MAX - 1);
    endcase
  end

  assign bitReady  = (chipCnt == '0);
  assign accept    = bitValid && bitReady;
  assign stb.load  = accept;
  assign stb.oqpsk = qpskMode;

  always_ff @(posedge clk) begin
    if (rst) begin
      chipCnt <= '0;
      spanM1  <= '0;
      envGate <= 1'b0;
    end else if (accept) begin
      envGate <= 1'b1;
      spanM1  <= newSpanM1;
      chipCnt <= (newSpanM1 == '0) ? '0 : CNT_W'(1);
    end else if (chipCnt != '0) begin
      envGate <= 1'b1;
      chipCnt <= (chipCnt == spanM1) ? '0 : chipCnt + CNT_W'(1);
    end else begin
      envGate <= 1'b0;
    end
  end

  // R8: idle boundary gates the envelope off
  p_idle_env_r8: assert property (@(posedge clk) disable iff (rst)
    (bitReady && !bitValid) |=> !envGate);
  // R7: a spread bit keeps ready low in the following slot
  p_spread_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && spreadSel != 2'b00) |=> (!bitReady && envGate));
endmodule

// File: rtl/ppm_datapath.sv
module ppm_datapath
  import ppm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  ppm_strobe_t          stb,
  input  logic                 bitData,
  output logic [PHASE_CNT-1:0] phaseSel,
  output logic [PHASE_CNT-1:0] phaseSelN
);
  logic iBit, qBit, laneQ;
  logic nextI, nextQ, nextLane;
  logic [PHASE_CNT-1:0] selNext;

  always_comb begin
    nextI = iBit;
    nextQ = qBit;
    nextLane = laneQ;
    if (stb.load) begin
      if (stb.oqpsk) begin
        if (laneQ) nextQ = bitData;
        else       nextI = bitData;
        nextLane = ~laneQ;
      end else begin
        nextI = bitData;
        nextQ = bitData;
        nextLane = 1'b0;
      end
    end
  end

  for (genvar k = 0; k < PHASE_CNT; k++) begin : g_decode
    assign selNext[k] = (grayIndex(nextI, nextQ) == 2'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iBit      <= 1'b0;
      qBit      <= 1'b0;
      laneQ     <= 1'b0;
      phaseSel  <= PHASE_CNT'(1);
      phaseSelN <= ~PHASE_CNT'(1);
    end else begin
      iBit      <= nextI;
      qBit      <= nextQ;
      laneQ     <= nextLane;
      phaseSel  <= selNext;
      phaseSelN <= ~selNext;
    end
  end

  // R1: exactly one phase selected
  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $countones(phaseSel) == 1);
  // R2: complementary path aligned
  p_compl_r2: assert property (@(posedge clk) disable iff (rst)
    phaseSelN == ~phaseSel);
  // R4: an offset-QPSK bit never turns the phase by half a cycle
  p_no_half_turn_r4: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.oqpsk) |=>
      phaseSel != {$past(phaseSel[1:0]), $past(phaseSel[3:2])});
  // R8: without a load the phase is held
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> $stable(phaseSel));
endmodule

// File: rtl/pulse_phase_mapper.sv
module pulse_phase_mapper
  import ppm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        qpskMode,
  input  logic [1:0]  spreadSel,
  input  logic        bitValid,
  input  logic        bitData,
  output logic        bitReady,
  output logic [3:0]  phaseSel,
  output logic [3:0]  phaseSelN,
  output logic        envGate
);
  ppm_strobe_t stb;

  ppm_ctrl u_ctrl (
    .clk(clk), .rst(rst), .qpskMode(qpskMode), .spreadSel(spreadSel),
    .bitValid(bitValid), .bitReady(bitReady), .envGate(envGate), .stb(stb)
  );

  ppm_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .bitData(bitData),
    .phaseSel(phaseSel), .phaseSelN(phaseSelN)
  );
endmodule

// File: tb/pulse_phase_mapper_test.sv
module pulse_phase_mapper_test;
  logic clk = 1'b0;
  logic rst, qpskMode, bitValid, bitData;
  logic [1:0] spreadSel;
  logic bitReady, envGate;
  logic [3:0] phaseSel, phaseSelN;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic refI, refQ, refLane, refEnv;
  int refCnt, refSpan;

  always #5 clk = ~clk;

  pulse_phase_mapper uut (
    .clk(clk), .rst(rst), .qpskMode(qpskMode), .spreadSel(spreadSel),
    .bitValid(bitValid), .bitData(bitData), .bitReady(bitReady),
    .phaseSel(phaseSel), .phaseSelN(phaseSelN), .envGate(envGate)
  );

  function automatic logic [3:0] expSel(input logic i, input logic q);
    case ({i, q})
      2'b00: return 4'b0001;
      2'b01: return 4'b0010;
      2'b11: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic int spanOf(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic refReset();
    refI = 0; refQ = 0; refLane = 0; refEnv = 0; refCnt = 0; refSpan = 1;
  endtask

  // drive at negedge, update model, check after the edge
  task automatic slot(input logic v, input logic d, input logic m, input logic [1:0] s);
    logic acc;
    bitValid = v; bitData = d; qpskMode = m; spreadSel = s;
    #1;
    check("R6 ready", {7'd0, bitReady}, {7'd0, refCnt == 0});
    acc = v && (refCnt == 0);
    if (acc) begin
      if (m) begin
        if (refLane) refQ = d; else refI = d;
        refLane = ~refLane;
      end else begin
        refI = d; refQ = d; refLane = 0;
      end
      refSpan = spanOf(s);
      refEnv = 1;
      refCnt = (refSpan == 1) ? 0 : 1;
    end else if (refCnt != 0) begin
      refEnv = 1;
      refCnt = (refCnt == refSpan - 1) ? 0 : refCnt + 1;
    end else begin
      refEnv = 0;
    end
    @(posedge clk); #1;
    check(m ? "R3 R4 sel" : "R5 sel", {4'd0, phaseSel}, {4'd0, expSel(refI, refQ)});
    check("R2 compl", {4'd0, phaseSelN}, {4'd0, ~expSel(refI, refQ)});
    check("R7 R8 env", {7'd0, envGate}, {7'd0, refEnv});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [3:0] prevSel;
    seed = 12345;
    void'($urandom(seed));
    rst = 1; bitValid = 0; bitData = 0; qpskMode = 1; spreadSel = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 sel", {4'd0, phaseSel}, 8'h01);
    check("R9 env", {7'd0, envGate}, 8'h00);
    check("R9 ready", {7'd0, bitReady}, 8'h01);
    rst = 0;
    refReset();

    // directed R4: OQPSK walk 1,1,0,0 -> I then Q alternately, 90 deg steps
    slot(1, 1, 1, 0); check("R4 270", {4'd0, phaseSel}, 8'h08);
    slot(1, 1, 1, 0); check("R4 180", {4'd0, phaseSel}, 8'h04);
    slot(1, 0, 1, 0); check("R4 90",  {4'd0, phaseSel}, 8'h02);
    slot(1, 0, 1, 0); check("R1 0",   {4'd0, phaseSel}, 8'h01);
    // R5: BPSK 1 -> 180, then OQPSK next goes to I lane
    slot(1, 1, 0, 0); check("R5 180", {4'd0, phaseSel}, 8'h04);
    slot(1, 0, 1, 0); check("R5 lane", {4'd0, phaseSel}, 8'h02);
    // R8: idle holds phase, env off
    prevSel = phaseSel;
    slot(0, 1, 1, 0);
    check("R8 hold", {4'd0, phaseSel}, {4'd0, prevSel});
    // R7: spread x4, inputs change mid-burst
    slot(1, 1, 1, 2'b11);
    for (int k = 0; k < 3; k++) slot(1, k[0], 0, 2'b00);
    slot(0, 0, 1, 0);
    check("R7 burst end", {7'd0, envGate}, 8'h00);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic v;
      prevSel = phaseSel;
      v = ($urandom % 10) < ((n / 500) % 2 ? 9 : 5);
      slot(v, 1'($urandom), ($urandom % 8) != 0, 2'($urandom));
      check("R1 onehot", {7'd0, $countones(phaseSel) == 1}, 8'h01);
      if (n % 700 == 699) begin
        rst = 1; @(posedge clk); #1;
        check("R9 sel", {4'd0, phaseSel}, 8'h01);
        check("R9 env", {7'd0, envGate}, 8'h00);
        @(negedge clk); rst = 0; refReset();
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule